// File: doc/BRIEF.md
# Cross-Clock Mailbox Register Pair

This block passes single words between two ports that run on unrelated clocks, A and B. It sits beside a data FIFO but does not use it. Each direction has its own mailbox register. Mail1 is loaded from port A and drained at port B. Mail2 is loaded from port B and drained at port A.

The writer sees an active-low full flag in its own clock domain. The flag drops on the edge that loads the word. Further loads are refused until the reader has taken the word. The reader sees an active-high ready indication in its own domain. A read with the mailbox select high clears that indication and sends an acknowledge back to the writer, which then raises the full flag again.

Each port also has a read-data multiplexer. It shows either the incoming mailbox or the FIFO output word that arrives from outside the block.

Top module: `xclk_mailbox_pair`

## Requirements
- R1: A port-A rising edge with `a_go`=1, `a_wr_sel`=1, `a_mb_sel`=1 and `mb1_full_n`=1 stores `a_wdata` in mail1 and drives `mb1_full_n` low from that edge on.
- R2: While `mb1_full_n` is low, port-A mailbox writes leave mail1 unchanged; the word later read at port B is the first one stored.
- R3: A port-B rising edge with `b_go`=1, `b_wr_sel`=0, `b_mb_sel`=1 and `mb1_ready`=1 drops `mb1_ready` at that edge, and `mb1_full_n` is high again no later than two port-A edges after it.
- R4: After a mail1 load, `mb1_ready` is high no later than two port-B edges after the loading edge, and it is only high while `mb1_full_n` is low.
- R5: A port-B mailbox read while `mb1_ready` is low returns the last stored mail1 word and changes neither `mb1_ready` nor `mb1_full_n`.
- R6: A read bus with its write/read select at 0 shows the incoming mailbox when the mailbox select is 1 and the FIFO word when it is 0. With the write/read select at 1 it shows all zeros.
- R7: Mail2 works the same way with the ports swapped: port-B writes load it and drive `mb2_full_n` low, `mb2_ready` rises in the port-A domain, and a port-A mailbox read clears it.
- R8: While `rst_n` is low, both full flags are high, both ready indications are low and both mailbox words are zero.
- R9: Traffic in one mailbox leaves the other mailbox's flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| clk_a | input | 1 | Port-A clock |
| a_go | input | 1 | Port-A access on this edge |
| a_wr_sel | input | 1 | Port-A write (1) or read (0) |
| a_mb_sel | input | 1 | Port-A mailbox select |
| a_wdata | input | WIDTH | Port-A write word |
| a_fifo_rdata | input | WIDTH | FIFO output word for port A |
| a_rdata | output | WIDTH | Port-A read bus |
| mb1_full_n | output | 1 | Mail1 full, active low, clk_a domain |
| mb2_ready | output | 1 | Mail2 word waiting, clk_a domain |
| clk_b | input | 1 | Port-B clock |
| b_go | input | 1 | Port-B access on this edge |
| b_wr_sel | input | 1 | Port-B write (1) or read (0) |
| b_mb_sel | input | 1 | Port-B mailbox select |
| b_wdata | input | WIDTH | Port-B write word |
| b_fifo_rdata | input | WIDTH | FIFO output word for port B |
| b_rdata | output | WIDTH | Port-B read bus |
| mb2_full_n | output | 1 | Mail2 full, active low, clk_b domain |
| mb1_ready | output | 1 | Mail1 word waiting, clk_b domain |

## Verification
The assertions assume that each port's controls are synchronous to that port's clock and that `rst_n` holds both domains in reset together. They also assume that a ready indication seen at a reader edge still reflects the writer's toggle, which needs the synchronizer chains to settle. The bench drives every control on the falling edge of its own clock and releases reset only after several edges of both clocks. It waits at least two destination edges before it relies on a crossed event, so no check depends on how the two clock phases line up.

// File: rtl/xclk_mailbox_pair.sv
module xclk_mailbox_pair #(
  parameter int WIDTH       = 36,
  parameter int SYNC_STAGES = 2
) (
  input  logic             rst_n,
  input  logic             clk_a,
  input  logic             a_go,
  input  logic             a_wr_sel,
  input  logic             a_mb_sel,
  input  logic [WIDTH-1:0] a_wdata,
  input  logic [WIDTH-1:0] a_fifo_rdata,
  output logic [WIDTH-1:0] a_rdata,
  output logic             mb1_full_n,
  output logic             mb2_ready,
  input  logic             clk_b,
  input  logic             b_go,
  input  logic             b_wr_sel,
  input  logic             b_mb_sel,
  input  logic [WIDTH-1:0] b_wdata,
  input  logic [WIDTH-1:0] b_fifo_rdata,
  output logic [WIDTH-1:0] b_rdata,
  output logic             mb2_full_n,
  output logic             mb1_ready
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [WIDTH-1:0] mail1_q, mail2_q;
  logic             ld1_tog, rd1_tog, ld2_tog, rd2_tog;
  logic [LAST:0]    ld1_sync, rd1_sync, ld2_sync, rd2_sync;
  logic             wr1, rd1, wr2, rd2;

  assign mb1_full_n = ~(ld1_tog ^ rd1_sync[LAST]);
  assign mb1_ready  = ld1_sync[LAST] ^ rd1_tog;
  assign mb2_full_n = ~(ld2_tog ^ rd2_sync[LAST]);
  assign mb2_ready  = ld2_sync[LAST] ^ rd2_tog;

  assign wr1 = a_go &  a_wr_sel & a_mb_sel & mb1_full_n;
  assign rd2 = a_go & ~a_wr_sel & a_mb_sel & mb2_ready;
  assign wr2 = b_go &  b_wr_sel & b_mb_sel & mb2_full_n;
  assign rd1 = b_go & ~b_wr_sel & b_mb_sel & mb1_ready;

  always_ff @(posedge clk_a or negedge rst_n) begin
    if (!rst_n) begin
      mail1_q  <= '0;
      ld1_tog  <= 1'b0;
      rd2_tog  <= 1'b0;
      rd1_sync <= '0;
      ld2_sync <= '0;
    end else begin
      if (wr1) begin
        mail1_q <= a_wdata;
        ld1_tog <= ~ld1_tog;
      end
      if (rd2) rd2_tog <= ~rd2_tog;
      rd1_sync <= {rd1_sync[LAST-1:0], rd1_tog};
      ld2_sync <= {ld2_sync[LAST-1:0], ld2_tog};
    end
  end

  always_ff @(posedge clk_b or negedge rst_n) begin
    if (!rst_n) begin
      mail2_q  <= '0;
      ld2_tog  <= 1'b0;
      rd1_tog  <= 1'b0;
      ld1_sync <= '0;
      rd2_sync <= '0;
    end else begin
      if (wr2) begin
        mail2_q <= b_wdata;
        ld2_tog <= ~ld2_tog;
      end
      if (rd1) rd1_tog <= ~rd1_tog;
      ld1_sync <= {ld1_sync[LAST-1:0], ld1_tog};
      rd2_sync <= {rd2_sync[LAST-1:0], rd2_tog};
    end
  end

  assign a_rdata = a_wr_sel ? '0 : (a_mb_sel ? mail2_q : a_fifo_rdata);
  assign b_rdata = b_wr_sel ? '0 : (b_mb_sel ? mail1_q : b_fifo_rdata);

endmodule

// File: rtl/xclk_mailbox_pair_chk.sv
module xclk_mailbox_pair_chk #(
  parameter int WIDTH = 36
) (
  input logic             rst_n,
  input logic             clk_a,
  input logic             clk_b,
  input logic             a_go,
  input logic             a_wr_sel,
  input logic             a_mb_sel,
  input logic [WIDTH-1:0] a_wdata,
  input logic             b_go,
  input logic             b_wr_sel,
  input logic             b_mb_sel,
  input logic [WIDTH-1:0] b_wdata,
  input logic             mb1_full_n,
  input logic             mb1_ready,
  input logic             mb2_full_n,
  input logic             mb2_ready,
  input logic [WIDTH-1:0] mail1_q,
  input logic [WIDTH-1:0] mail2_q
);

  AST_MAIL1_LOAD: assert property (@(posedge clk_a) disable iff (!rst_n)
    (a_go && a_wr_sel && a_mb_sel && mb1_full_n) |=> (!mb1_full_n && mail1_q == $past(a_wdata))); // R1

  AST_MAIL1_HELD: assert property (@(posedge clk_a) disable iff (!rst_n)
    !mb1_full_n |=> $stable(mail1_q)); // R2

  AST_MAIL1_READ_CLEARS: assert property (@(posedge clk_b) disable iff (!rst_n)
    (b_go && !b_wr_sel && b_mb_sel && mb1_ready) |=> !mb1_ready); // R3

  AST_MAIL1_READY_IMPLIES_FULL: assert property (@(posedge clk_b) disable iff (!rst_n)
    mb1_ready |-> !mb1_full_n); // R4

  AST_MAIL2_LOAD: assert property (@(posedge clk_b) disable iff (!rst_n)
    (b_go && b_wr_sel && b_mb_sel && mb2_full_n) |=> (!mb2_full_n && mail2_q == $past(b_wdata))); // R7

  AST_MAIL2_HELD: assert property (@(posedge clk_b) disable iff (!rst_n)
    !mb2_full_n |=> $stable(mail2_q)); // R7

  AST_MAIL2_READ_CLEARS: assert property (@(posedge clk_a) disable iff (!rst_n)
    (a_go && !a_wr_sel && a_mb_sel && mb2_ready) |=> !mb2_ready); // R7

  AST_MAIL2_READY_IMPLIES_FULL: assert property (@(posedge clk_a) disable iff (!rst_n)
    mb2_ready |-> !mb2_full_n); // R7

endmodule

bind xclk_mailbox_pair xclk_mailbox_pair_chk #(.WIDTH(WIDTH)) chk_i (.*);

// File: tb/xclk_mailbox_pair_tb_top.sv
`timescale 1ns/1ps
module xclk_mailbox_pair_tb_top;
  localparam int W = 36;

  logic clk_a = 1'b0, clk_b = 1'b0, rst_n = 1'b0;
  logic a_go = 0, a_wr_sel = 0, a_mb_sel = 0;
  logic b_go = 0, b_wr_sel = 0, b_mb_sel = 0;
  logic [W-1:0] a_wdata = '0, a_fifo_rdata = '0, b_wdata = '0, b_fifo_rdata = '0;
  logic [W-1:0] a_rdata, b_rdata;
  logic mb1_full_n, mb2_ready, mb2_full_n, mb1_ready;

  int total = 0, fails = 0;
  logic [W-1:0] exp_a_q[$], exp_b_q[$];
  string        tag_a_q[$], tag_b_q[$];

  always #10 clk_a = ~clk_a;
  always #13 clk_b = ~clk_b;

  xclk_mailbox_pair #(.WIDTH(W)) dut_i (.*);

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  task automatic a_op(input logic wr, input logic mb, input logic [W-1:0] d);
    @(negedge clk_a); #2;
    a_go = 1; a_wr_sel = wr; a_mb_sel = mb; a_wdata = d;
    @(negedge clk_a); #2;
    a_go = 0; a_wr_sel = 0; a_mb_sel = 0;
  endtask

  task automatic b_op(input logic wr, input logic mb, input logic [W-1:0] d);
    @(negedge clk_b); #2;
    b_go = 1; b_wr_sel = wr; b_mb_sel = mb; b_wdata = d;
    @(negedge clk_b); #2;
    b_go = 0; b_wr_sel = 0; b_mb_sel = 0;
  endtask

  task automatic a_read(input logic mb, input logic [W-1:0] exp, input string tag);
    exp_a_q.push_back(exp); tag_a_q.push_back(tag);
    a_op(1'b0, mb, '0);
  endtask

  task automatic b_read(input logic mb, input logic [W-1:0] exp, input string tag);
    exp_b_q.push_back(exp); tag_b_q.push_back(tag);
    b_op(1'b0, mb, '0);
  endtask

  always @(negedge clk_a) if (rst_n && a_go && !a_wr_sel) begin
    if (exp_a_q.size() == 0) chk("scoreboard A", a_rdata, 'x);
    else chk(tag_a_q.pop_front(), a_rdata, exp_a_q.pop_front());
  end

  always @(negedge clk_b) if (rst_n && b_go && !b_wr_sel) begin
    if (exp_b_q.size() == 0) chk("scoreboard B", b_rdata, 'x);
    else chk(tag_b_q.pop_front(), b_rdata, exp_b_q.pop_front());
  end

  initial begin
    repeat (200000) @(posedge clk_a);
    total++; fails++;
    $display("FAIL watchdog: actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk_b);
    chk("R8 mb1_full_n", mb1_full_n, 1);
    chk("R8 mb2_full_n", mb2_full_n, 1);
    chk("R8 mb1_ready", mb1_ready, 0);
    chk("R8 mb2_ready", mb2_ready, 0);
    b_mb_sel = 1; a_mb_sel = 1; #1;
    chk("R8 mail1 word", b_rdata, '0);
    chk("R8 mail2 word", a_rdata, '0);
    b_mb_sel = 0; a_mb_sel = 0;
    @(negedge clk_a); rst_n = 1;
    repeat (3) @(negedge clk_b);

    b_fifo_rdata = 36'h9_1234_5678;
    a_fifo_rdata = 36'h4_CAFE_0001;
    b_read(0, 36'h9_1234_5678, "R6 fifo B");
    a_read(0, 36'h4_CAFE_0001, "R6 fifo A");

    a_op(1, 1, 36'hA_1111_0001);
    chk("R1 full after write", mb1_full_n, 0);
    chk("R9 mb2_full_n", mb2_full_n, 1);
    chk("R9 mb2_ready", mb2_ready, 0);
    repeat (2) @(posedge clk_b); #1;
    chk("R4 ready after two edges", mb1_ready, 1);

    a_op(1, 1, 36'hB_2222_0002);
    chk("R2 still full", mb1_full_n, 0);
    repeat (2) @(posedge clk_b);
    b_read(1, 36'hA_1111_0001, "R2 first word kept");
    chk("R3 ready cleared", mb1_ready, 0);
    repeat (2) @(posedge clk_a); #1;
    chk("R3 full released", mb1_full_n, 1);

    b_read(1, 36'hA_1111_0001, "R5 stale read data");
    chk("R5 ready unchanged", mb1_ready, 0);
    repeat (3) @(posedge clk_a); #1;
    chk("R5 full unchanged", mb1_full_n, 1);

    a_op(1, 1, 36'hB_2222_0002);
    repeat (2) @(posedge clk_b);
    b_read(1, 36'hB_2222_0002, "R1 new word");

    b_op(1, 1, 36'h3_0000_00E1);
    chk("R7 mb2 full", mb2_full_n, 0);
    chk("R9 mb1_full_n", mb1_full_n, 1);
    repeat (2) @(posedge clk_a); #1;
    chk("R7 mb2 ready", mb2_ready, 1);
    b_op(1, 1, 36'h3_0000_00E2);
    a_read(1, 36'h3_0000_00E1, "R7 mail2 word");
    chk("R7 mb2 ready cleared", mb2_ready, 0);
    repeat (2) @(posedge clk_b); #1;
    chk("R7 mb2 full released", mb2_full_n, 1);
    chk("R9 mb1_ready", mb1_ready, 0);

    @(negedge clk_b); b_wr_sel = 1; b_mb_sel = 1; #1;
    chk("R6 B write zeros", b_rdata, '0);
    b_wr_sel = 0; b_mb_sel = 0;
    @(negedge clk_a); a_wr_sel = 1; a_mb_sel = 1; #1;
    chk("R6 A write zeros", a_rdata, '0);
    a_wr_sel = 0; a_mb_sel = 0;

    repeat (4) @(negedge clk_b);
    chk("scoreboard drained", W'(exp_a_q.size() + exp_b_q.size()), '0);
    summary();
    $finish;
  end
endmodule